// File: doc/BRIEF.md
# Power-Up Configuration Sequencer

This block takes a link chip from power-on reset to an operational state. It first waits for the on-chip fuse contents to finish loading. It then picks a configuration path from two inputs: the fused status flag and a pin that chooses which control channel is used.

- A fused part goes straight to the power-up stage.
- An unfused part that is set up to use the two-wire bus waits for an external agent to write its configuration and raise a done strobe.
- An unfused part that is set up to use the in-band control channel has no high-speed link. It parks in a terminal unreachable state.

In the power-up stage the block waits until every subsystem ready line has been high together for a programmable number of consecutive cycles, and only then declares itself ready. If any ready line drops while the block is ready, it falls back to waiting. A fuse load that never completes is caught by a timeout. The timeout raises a sticky error flag, and the part is then handled as unfused.

Top module: `bringup_seq`

## Requirements
- R1: Synchronous active-low reset. Any clock edge that samples `rst_n` low puts the block in the fuse-load state (`state_o` = 0) from any state. At that point `ready_o`, `unreach_o`, `fuse_err_o`, `twowire_en_o` and `inband_en_o` are all 0.
- R2: In fuse-load, the edge that samples `fuse_done_i`=1 with `fused_i`=1 moves the block to power-up (`state_o` = 2), whatever the select pin is.
- R3: In fuse-load, the edge that samples `fuse_done_i`=1 with `fused_i`=0 and `sel_inband_i`=0 moves the block to wait-for-configuration (`state_o` = 1), with `twowire_en_o`=1. In that state, an edge that samples `cfg_done_i`=1 moves the block to power-up.
- R4: In fuse-load, the edge that samples `fuse_done_i`=1 with `fused_i`=0 and `sel_inband_i`=1 moves the block to unreachable (`state_o` = 4) with `unreach_o`=1. The block stays there until reset, whatever the other inputs do, and both enables stay 0.
- R5: In power-up, the block moves to ready (`state_o` = 3) on the HOLD_CYCLES-th consecutive edge at which every bit of `ready_vec_i` is 1. Any edge with a zero bit restarts the count.
- R6: In ready, `ready_o`, `twowire_en_o` and `inband_en_o` are all 1.
- R7: The select pin is sampled only at the fuse-load decision. While the block waits for configuration, changes on `sel_inband_i` have no effect on the state, and `inband_en_o` stays 0.
- R8: In ready, an edge that samples any bit of `ready_vec_i` low returns the block to power-up, and `ready_o` drops.
- R9: If fuse-load sees no `fuse_done_i` for FUSE_TIMEOUT edges, the block leaves fuse-load at that edge with `fuse_err_o`=1. It then takes the unfused path chosen by the select pin. `fuse_err_o` holds until reset, and a late `fuse_done_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fuse_done_i | input | 1 | Fuse contents loaded |
| fused_i | input | 1 | Part has been fused |
| sel_inband_i | input | 1 | 1 = configure over the in-band channel, 0 = over the two-wire bus |
| cfg_done_i | input | 1 | External configuration write complete |
| ready_vec_i | input | NUM_READY | Subsystem ready lines |
| state_o | output | 3 | Current state: 0 fuse-load, 1 wait-config, 2 power-up, 3 ready, 4 unreachable |
| ready_o | output | 1 | Block is ready |
| unreach_o | output | 1 | Unfused part set for the in-band channel; terminal |
| fuse_err_o | output | 1 | Sticky fuse-load timeout flag |
| twowire_en_o | output | 1 | Two-wire control interface enable |
| inband_en_o | output | 1 | In-band control channel enable |

## Verification
The hardest situation to reach is the fuse-load timeout. Reaching it means holding the load-done input low for the full window. The bench then checks, at the exact boundary edge, that the block is still in fuse-load one edge before the timeout and has left on the timeout edge itself. After the timeout the stimulus raises a late load-done with the fused flag set, to show that it has no effect. The hold window is probed the same way: a run one cycle short, a one-cycle gap, and a vector with a single bit low each have to leave the block in power-up.

// File: rtl/bringup_pkg.sv
// Package: shared state encoding for the power-up sequencer.
// Assumes a 3-bit state is visible at the top-level ports.
package bringup_pkg;
    typedef enum logic [2:0] {
        ST_FUSE   = 3'd0,
        ST_CFG    = 3'd1,
        ST_PWRUP  = 3'd2,
        ST_READY  = 3'd3,
        ST_UNREACH = 3'd4
    } seq_state_t;
endpackage

// File: rtl/bringup_fuse_timer.sv
// Module: bringup_fuse_timer
// Counts the edges spent in fuse-load and raises 'expired' on the edge that
// would be the TIMEOUT-th without a load-done. Assumes 'run' is high only in
// fuse-load; the count clears whenever 'run' is low.
module bringup_fuse_timer #(
    parameter int TIMEOUT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fuse_done,
    output logic expired
);
    localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

    logic [TW-1:0] cnt;

    // Purpose: flag the last allowed edge without a load-done.
    always_comb begin
        expired = run && !fuse_done && (cnt == TW'(TIMEOUT - 1));
    end

    // Purpose: advance the wait counter while fuse-load is pending.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || fuse_done) begin
            cnt <= '0;
        end else if (cnt != TW'(TIMEOUT - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bringup_ready_qual.sv
// Module: bringup_ready_qual
// Qualifies the subsystem ready vector. 'hold_met' is high on the HOLD-th
// consecutive armed edge at which every bit is set. Assumes 'arm' is high only
// in power-up; any gap or disarm restarts the count.
module bringup_ready_qual #(
    parameter int NUM_READY = 4,
    parameter int HOLD      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm,
    input  logic [NUM_READY-1:0] ready_vec,
    output logic                 all_ready,
    output logic                 hold_met
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [CW-1:0] run_len;

    // Purpose: reduce the vector and detect the end of the hold window.
    always_comb begin
        all_ready = &ready_vec;
        hold_met  = arm && all_ready && (run_len == CW'(HOLD - 1));
    end

    // Purpose: count consecutive all-ready edges while armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm || !all_ready) begin
            run_len <= '0;
        end else if (run_len != CW'(HOLD - 1)) begin
            run_len <= run_len + 1'b1;
        end
    end
endmodule

// File: rtl/bringup_fsm.sv
// Module: bringup_fsm
// Main sequencing state machine. Chooses the configuration path after fuse
// load, holds the sticky fuse error, and decodes the enables from the state.
// Assumes the timer and the ready qualifier are driven from its own state.
module bringup_fsm
    import bringup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fuse_done,
    input  logic       fused,
    input  logic       sel_inband,
    input  logic       cfg_done,
    input  logic       fuse_expired,
    input  logic       all_ready,
    input  logic       hold_met,
    output seq_state_t state,
    output logic       fuse_err,
    output logic       ready,
    output logic       unreach,
    output logic       twowire_en,
    output logic       inband_en
);
    seq_state_t nxt;

    // Purpose: compute the next state from the current state and inputs.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_FUSE: begin
                if (fuse_done && fused)      nxt = ST_PWRUP;
                else if (fuse_done || fuse_expired)
                    nxt = sel_inband ? ST_UNREACH : ST_CFG;
            end
            ST_CFG:     if (cfg_done) nxt = ST_PWRUP;
            ST_PWRUP:   if (hold_met) nxt = ST_READY;
            ST_READY:   if (!all_ready) nxt = ST_PWRUP;
            ST_UNREACH: nxt = ST_UNREACH;
            default:    nxt = ST_FUSE;
        endcase
    end

    // Purpose: hold the state and the sticky fuse-timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_FUSE;
            fuse_err <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_FUSE && fuse_expired) fuse_err <= 1'b1;
        end
    end

    // Purpose: decode the status flags and interface enables.
    always_comb begin
        ready      = (state == ST_READY);
        unreach    = (state == ST_UNREACH);
        twowire_en = (state == ST_CFG) || (state == ST_READY);
        inband_en  = (state == ST_READY);
    end
endmodule

// File: rtl/bringup_seq.sv
// Module: bringup_seq (top)
// Power-up configuration sequencer: fuse load, path choice, external
// configuration wait, ready qualification. Assumes all inputs are synchronous
// to clk; the fuse memory, bus engines and PLL live outside.
module bringup_seq
    import bringup_pkg::*;
#(
    parameter int NUM_READY    = 4,
    parameter int HOLD_CYCLES  = 4,
    parameter int FUSE_TIMEOUT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fuse_done_i,
    input  logic                 fused_i,
    input  logic                 sel_inband_i,
    input  logic                 cfg_done_i,
    input  logic [NUM_READY-1:0] ready_vec_i,
    output logic [2:0]           state_o,
    output logic                 ready_o,
    output logic                 unreach_o,
    output logic                 fuse_err_o,
    output logic                 twowire_en_o,
    output logic                 inband_en_o
);
    seq_state_t st;
    logic       expired;
    logic       all_rdy;
    logic       hold_ok;

    bringup_fuse_timer #(.TIMEOUT(FUSE_TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (st == ST_FUSE),
        .fuse_done (fuse_done_i),
        .expired   (expired)
    );

    bringup_ready_qual #(.NUM_READY(NUM_READY), .HOLD(HOLD_CYCLES)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (st == ST_PWRUP),
        .ready_vec (ready_vec_i),
        .all_ready (all_rdy),
        .hold_met  (hold_ok)
    );

    bringup_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fuse_done    (fuse_done_i),
        .fused        (fused_i),
        .sel_inband   (sel_inband_i),
        .cfg_done     (cfg_done_i),
        .fuse_expired (expired),
        .all_ready    (all_rdy),
        .hold_met     (hold_ok),
        .state        (st),
        .fuse_err     (fuse_err_o),
        .ready        (ready_o),
        .unreach      (unreach_o),
        .twowire_en   (twowire_en_o),
        .inband_en    (inband_en_o)
    );

    // Purpose: expose the state code on a plain port.
    always_comb state_o = st;
endmodule

// File: rtl/bringup_seq_chk.sv
// Module: bringup_seq_chk
// Property checker for bringup_seq, attached by bind. Observes ports only.
module bringup_seq_chk #(
    parameter int NUM_READY = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fuse_done_i,
    input logic                 fused_i,
    input logic [NUM_READY-1:0] ready_vec_i,
    input logic [2:0]           state_o,
    input logic                 ready_o,
    input logic                 unreach_o,
    input logic                 fuse_err_o,
    input logic                 twowire_en_o,
    input logic                 inband_en_o
);
    logic seen_edge;
    logic rst_prev;

    // Purpose: remember whether reset was sampled at the previous edge.
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        rst_prev  <= rst_n;
    end

    // Purpose: after an edge that sampled reset, the block sits in fuse-load.
    always @(posedge clk) begin
        if (seen_edge === 1'b1 && rst_prev === 1'b0)
            AST_RESET_TO_FUSE: assert (state_o == 3'd0 && !fuse_err_o); // R1
    end

    AST_FUSED_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && fuse_done_i && fused_i) |=> state_o == 3'd2); // R2
    AST_UNREACH_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        unreach_o |=> (unreach_o && !twowire_en_o && !inband_en_o)); // R4
    AST_READY_NEEDS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(&ready_vec_i)); // R5
    AST_READY_BOTH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (twowire_en_o && inband_en_o)); // R6
    AST_CFG_NO_INBAND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1) |-> !inband_en_o); // R7
    AST_DROP_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !(&ready_vec_i)) |=> (state_o == 3'd2 && !ready_o)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_err_o |=> fuse_err_o); // R9
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ready_o, unreach_o})); // R4
endmodule

bind bringup_seq bringup_seq_chk #(.NUM_READY(NUM_READY)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fuse_done_i  (fuse_done_i),
    .fused_i      (fused_i),
    .ready_vec_i  (ready_vec_i),
    .state_o      (state_o),
    .ready_o      (ready_o),
    .unreach_o    (unreach_o),
    .fuse_err_o   (fuse_err_o),
    .twowire_en_o (twowire_en_o),
    .inband_en_o  (inband_en_o)
);

// File: tb/bringup_seq_test.sv
// Directed bench for bringup_seq: one task per scenario, inputs driven at the
// falling edge, outputs sampled at the falling edge.
module bringup_seq_test;
    localparam int NR   = 4;
    localparam int HOLD = 4;
    localparam int TMO  = 16;
    localparam logic [2:0] S_FUSE = 3'd0, S_CFG = 3'd1, S_PWR = 3'd2,
                           S_RDY = 3'd3, S_UNR = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fuse_done = 1'b0, fused = 1'b0, sel = 1'b0, cfg_done = 1'b0;
    logic [NR-1:0] rdy = '0;
    logic [2:0]    state;
    logic          ready, unreach, ferr, tw_en, ib_en;
    int            checks = 0;
    int            errors = 0;

    always #2 clk = ~clk;

    bringup_seq #(.NUM_READY(NR), .HOLD_CYCLES(HOLD), .FUSE_TIMEOUT(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .fuse_done_i(fuse_done), .fused_i(fused),
        .sel_inband_i(sel), .cfg_done_i(cfg_done), .ready_vec_i(rdy),
        .state_o(state), .ready_o(ready), .unreach_o(unreach),
        .fuse_err_o(ferr), .twowire_en_o(tw_en), .inband_en_o(ib_en)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; fuse_done = 0; fused = 0; sel = 0; cfg_done = 0; rdy = '0;
        step(3);
        rst_n = 1'b1;
    endtask

    // Check every output for the fuse-load reset state.
    task automatic expect_idle(input string tag);
        chk({5'd0, state}, 8'd0, tag);
        chk({3'd0, ready, unreach, ferr, tw_en, ib_en}, 8'd0, tag);
    endtask

    task automatic t_reset();
        do_reset();
        expect_idle("R1 reset state");
    endtask

    // Hold the whole vector for HOLD edges from power-up and reach ready.
    task automatic reach_ready(input string tag);
        rdy = '1;
        step(HOLD - 1);
        chk({5'd0, state}, {5'd0, S_PWR}, {tag, " R5 short of hold"});
        step(1);
        chk({5'd0, state}, {5'd0, S_RDY}, {tag, " R5 hold met"});
        chk({5'd0, ready, tw_en, ib_en}, 8'h07, {tag, " R6 ready enables"});
    endtask

    task automatic t_fused();
        do_reset();
        fuse_done = 1; fused = 1; sel = 1;
        step(1);
        fuse_done = 0;
        chk({5'd0, state}, {5'd0, S_PWR}, "R2 fused skips config");
        chk({7'd0, unreach}, 8'd0, "R2 no unreachable when fused");
        reach_ready("fused");
    endtask

    task automatic t_twowire();
        do_reset();
        fuse_done = 1; fused = 0; sel = 0;
        step(1);
        fuse_done = 0;
        chk({5'd0, state}, {5'd0, S_CFG}, "R3 wait config");
        chk({6'd0, tw_en, ib_en}, 8'h02, "R3 two-wire enabled only");
        sel = 1;
        step(3);
        chk({5'd0, state}, {5'd0, S_CFG}, "R7 select change ignored");
        chk({7'd0, ib_en}, 8'd0, "R7 in-band off while configuring");
        sel = 0;
        cfg_done = 1;
        step(1);
        cfg_done = 0;
        chk({5'd0, state}, {5'd0, S_PWR}, "R3 config done to power-up");
    endtask

    task automatic t_hold_gap();
        // from power-up after t_twowire
        rdy = '1;
        step(HOLD - 1);
        rdy = '0;
        step(1);
        rdy = '1;
        step(HOLD - 1);
        chk({5'd0, state}, {5'd0, S_PWR}, "R5 gap restarts count");
        rdy = 4'b1011;
        step(HOLD + 1);
        chk({5'd0, state}, {5'd0, S_PWR}, "R5 partial vector not ready");
        reach_ready("gap");
    endtask

    task automatic t_drop();
        rdy[2] = 1'b0;
        step(1);
        chk({5'd0, state}, {5'd0, S_PWR}, "R8 drop returns to power-up");
        chk({7'd0, ready}, 8'd0, "R8 ready flag low");
        reach_ready("after drop");
    endtask

    task automatic t_unreach();
        do_reset();
        fuse_done = 1; fused = 0; sel = 1;
        step(1);
        fuse_done = 0;
        chk({5'd0, state}, {5'd0, S_UNR}, "R4 unreachable");
        chk({6'd0, unreach, ready}, 8'h02, "R4 unreachable flag");
        cfg_done = 1; rdy = '1; sel = 0;
        step(10);
        cfg_done = 0;
        chk({5'd0, state}, {5'd0, S_UNR}, "R4 terminal");
        chk({6'd0, tw_en, ib_en}, 8'd0, "R4 enables off");
        rst_n = 0;
        step(1);
        expect_idle("R1 reset from unreachable");
        rst_n = 1;
    endtask

    task automatic t_timeout(input logic pin);
        do_reset();
        sel = pin;
        step(TMO - 1);
        chk({5'd0, state}, {5'd0, S_FUSE}, "R9 still loading before timeout");
        chk({7'd0, ferr}, 8'd0, "R9 no error before timeout");
        step(1);
        chk({5'd0, state}, {5'd0, pin ? S_UNR : S_CFG}, "R9 timeout path");
        chk({7'd0, ferr}, 8'd1, "R9 error raised");
        if (!pin) begin
            fuse_done = 1; fused = 1;
            step(2);
            fuse_done = 0;
            chk({5'd0, state}, {5'd0, S_CFG}, "R9 late load-done ignored");
            cfg_done = 1;
            step(1);
            cfg_done = 0;
            chk({5'd0, state}, {5'd0, S_PWR}, "R3 config after timeout");
            chk({7'd0, ferr}, 8'd1, "R9 error sticky");
            rdy = '1;
            step(1);
            rst_n = 0;
            step(1);
            expect_idle("R1 reset from power-up");
            rst_n = 1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fused();
        t_drop();
        t_twowire();
        t_hold_gap();
        t_unreach();
        t_timeout(1'b0);
        t_timeout(1'b1);
        step(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule